// File: doc/BRIEF.md
# Single-Frame Network Interface with Byte Data Ports

This block is a minimal network controller for a system that has no DMA engine. It keeps one received frame and one frame to transmit in two internal byte buffers. The host moves every byte through a single data-port register, so a frame of N bytes takes N register reads or N register writes. A busy flag decides when the block may take a new incoming frame. The host clears that flag by acknowledging interrupt causes.

On the network side, incoming bytes arrive on a valid/ready/last stream. Outgoing bytes leave on a second stream of the same kind once the host has written the whole transmit frame.

The host side is a simple strobe bus. It has separate read and write strobes, a 6-bit byte address, 32-bit write and read data, and a level interrupt output. A read has its effect at the clock edge where the strobe is high. The read data is valid during that same cycle. One interrupt-control register serves three purposes:
- it acknowledges interrupt causes in priority order;
- it starts a soft reset when its test bit is written;
- it clears the test bit when it is read.

Top module: `sfnic`

## Requirements
- R1: After reset: busy reads 1; the receive count, transmit count and cause register read 0; irq is low. Address 0x00 reads the identification word 0x53464E49 and address 0x04 reads 0x43310000.
- R2: Reads of 0x18, of the transmit data port 0x20 and of any unlisted address return 0. Writes to 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change nothing that can be read back.
- R3: A new incoming frame is accepted (rx_ready high on its first byte) only while busy is 0 and the receive count at 0x0C is below MAX_LEN. Otherwise rx_ready is low.
- R4: When a frame completes (the last byte is taken):
  - the receive count becomes the frame length;
  - reading restarts at byte 0;
  - cause bit 1 (receive done) of register 0x14 is set and irq goes high.
  Busy becomes 1 when the first byte of the frame is accepted.
- R5: A read of 0x1C while the receive count is nonzero returns the next stored byte in arrival order in bits 7:0 and decrements the count. While the count is 0, the read returns 0 and nothing changes.
- R6: A write to 0x10 loads the transmit count if the value is at most MAX_LEN and loads 0 otherwise. It also restarts the transmit fill position at 0.
- R7: Each write to 0x20 stores bits 7:0 at the fill position. The write that makes the number of stored bytes equal to the transmit count launches the frame, clears the transmit count, sets cause bit 0 (transmit done) and sets busy to 1.
- R8: A launched frame leaves in write order on tx_data. tx_valid and the byte stay stable until tx_ready is high, and tx_last is high only on the final byte.
- R9: A write to 0x14 acts by priority: bit 0 set clears only transmit done; otherwise bit 1 set clears only receive done; otherwise bit 31 set performs the soft reset.
- R10: The soft reset clears both counts, the transmit stream and any partial state, then leaves 0x14 at 0x80000000 with busy at 1 and irq high.
- R11: A read of 0x14 returns its current value and then clears bit 31.
- R12: After any write to 0x14, busy equals 1 if any cause bit remains set and 0 otherwise. irq is high exactly when a cause bit is set.
- R13: Writes to 0x20 while the transmit count is 0 are ignored.
- R14: An incoming frame longer than MAX_LEN is fully consumed, but only its first MAX_LEN bytes are kept, and the receive count becomes MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 6 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt, high while any cause bit is set |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Block takes the incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Sink takes the outgoing byte |

## Verification
The bench builds the block with MAX_LEN set to 16 instead of 1514. This makes a full buffer, an oversize transmit count and a truncated incoming frame reachable within a few dozen cycles each. With that value, the full-buffer refusal and the truncation tests run at the exact boundary: count equal to MAX_LEN, and a frame three bytes longer than it. The outgoing stream is stalled on a repeating ready pattern, so the hold rule is exercised mid-frame as well as on the last byte.

// File: rtl/sfnic_pkg.sv
package sfnic_pkg;

  // Register offsets, decoded on the full 6-bit address
  localparam logic [5:0] A_ID_HI  = 6'h00;
  localparam logic [5:0] A_ID_LO  = 6'h04;
  localparam logic [5:0] A_BUSY   = 6'h08;
  localparam logic [5:0] A_RXCNT  = 6'h0C;
  localparam logic [5:0] A_TXCNT  = 6'h10;
  localparam logic [5:0] A_ICTL   = 6'h14;
  localparam logic [5:0] A_INFO   = 6'h18;
  localparam logic [5:0] A_RXPORT = 6'h1C;
  localparam logic [5:0] A_TXPORT = 6'h20;

  // Cause bit positions
  localparam int C_TXDONE = 0;
  localparam int C_RXDONE = 1;
  localparam int C_TEST   = 31;

  // Transmit count load: out-of-range values become zero
  function automatic logic [31:0] clamp_len(logic [31:0] v, int unsigned mx);
    return (v <= mx) ? v : 32'd0;
  endfunction

  // Bit 31 acts only when neither acknowledge bit is set
  function automatic logic is_soft(logic [31:0] w);
    return !w[C_TXDONE] && !w[C_RXDONE] && w[C_TEST];
  endfunction

  // Prioritised acknowledge: bit 0 wins over bit 1
  function automatic logic [31:0] ack_causes(logic [31:0] cur, logic [31:0] w);
    logic [31:0] r;
    r = cur;
    if (w[C_TXDONE])      r[C_TXDONE] = 1'b0;
    else if (w[C_RXDONE]) r[C_RXDONE] = 1'b0;
    return r;
  endfunction

  // Saturating fill position: stops at the buffer size
  function automatic int unsigned fill_next(int unsigned idx, int unsigned mx);
    return (idx < mx) ? idx + 1 : idx;
  endfunction

endpackage

// File: rtl/sfnic_rx.sv
module sfnic_rx
  import sfnic_pkg::*;
#(
  parameter int MAX_LEN = 1514,
  parameter int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  input  logic          can_accept,
  input  logic          pop,
  output logic [LW-1:0] count,
  output logic [7:0]    head,
  output logic          start_evt,
  output logic          done_evt,
  output logic          in_frame
);
  localparam int DEPTH = 1 << LW;

  logic [7:0]    mem_q [DEPTH];
  logic [LW-1:0] wr_idx_q, rd_idx_q, count_q;
  logic [LW-1:0] slot, fill;
  logic          in_frame_q, hs;

  assign s_ready   = in_frame_q || can_accept;
  assign hs        = s_valid && s_ready;
  assign slot      = in_frame_q ? wr_idx_q : '0;
  assign fill      = LW'(fill_next(32'(slot), MAX_LEN));
  assign start_evt = hs && !in_frame_q;
  assign done_evt  = hs && s_last;

  // Storage: a byte is kept only while the fill position still advances
  always_ff @(posedge clk) begin
    if (hs && !clr && (fill != slot)) mem_q[slot] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      in_frame_q <= 1'b0;
      wr_idx_q   <= '0;
      rd_idx_q   <= '0;
      count_q    <= '0;
    end else begin
      if (hs) begin
        wr_idx_q   <= fill;
        in_frame_q <= !s_last;
      end
      if (done_evt) begin
        count_q  <= fill;
        rd_idx_q <= '0;
      end else if (pop && (count_q != '0)) begin
        count_q  <= count_q - 1'b1;
        rd_idx_q <= rd_idx_q + 1'b1;
      end
    end
  end

  assign count    = count_q;
  assign head     = mem_q[rd_idx_q];
  assign in_frame = in_frame_q;
endmodule

// File: rtl/sfnic_tx.sv
module sfnic_tx
  import sfnic_pkg::*;
#(
  parameter int MAX_LEN = 1514,
  parameter int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cnt_wr,
  input  logic [31:0]   cnt_val,
  input  logic          data_wr,
  input  logic [7:0]    data_byte,
  output logic [LW-1:0] count,
  output logic          send_evt,
  output logic          m_valid,
  output logic [7:0]    m_data,
  output logic          m_last,
  input  logic          m_ready
);
  localparam int DEPTH = 1 << LW;

  logic [7:0]    mem_q [DEPTH];
  logic [LW-1:0] wr_ptr_q, count_q, send_len_q, send_idx_q;
  logic          sending_q, take, m_hs;

  assign take     = data_wr && (count_q != '0);
  assign send_evt = take && (LW'(wr_ptr_q + 1'b1) == count_q);
  assign m_hs     = sending_q && m_ready;

  always_ff @(posedge clk) begin
    if (take && !clr) mem_q[wr_ptr_q] <= data_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr_q   <= '0;
      count_q    <= '0;
      send_len_q <= '0;
      send_idx_q <= '0;
      sending_q  <= 1'b0;
    end else begin
      if (m_hs) begin
        if (m_last) sending_q <= 1'b0;
        else        send_idx_q <= send_idx_q + 1'b1;
      end
      if (cnt_wr) begin
        count_q  <= LW'(clamp_len(cnt_val, MAX_LEN));
        wr_ptr_q <= '0;
      end else if (send_evt) begin
        send_len_q <= count_q;
        send_idx_q <= '0;
        sending_q  <= 1'b1;
        count_q    <= '0;
        wr_ptr_q   <= '0;
      end else if (take) begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
      end
    end
  end

  assign count   = count_q;
  assign m_valid = sending_q;
  assign m_data  = mem_q[send_idx_q];
  assign m_last  = sending_q && (send_idx_q == LW'(send_len_q - 1'b1));
endmodule

// File: rtl/sfnic.sv
module sfnic
  import sfnic_pkg::*;
#(
  parameter int          MAX_LEN = 1514,
  parameter logic [31:0] ID_HI   = 32'h5346_4E49,
  parameter logic [31:0] ID_LO   = 32'h4331_0000,
  localparam int         LW      = $clog2(MAX_LEN + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  logic [31:0]   intctl, intctl_nx;
  logic          busy, busy_nx;
  logic          host_rd, wr_intctl, rd_intctl, soft_rst;
  logic          rd_rxport, wr_txcnt, wr_txport, rx_can_accept;
  logic [LW-1:0] rx_count, tx_count;
  logic [7:0]    rx_head;
  logic          rx_start, rx_done, rx_in_frame, tx_send;

  // Host decode (a write in the same cycle masks a read)
  assign host_rd   = bus_rd && !bus_wr;
  assign wr_intctl = bus_wr && (bus_addr == A_ICTL);
  assign rd_intctl = host_rd && (bus_addr == A_ICTL);
  assign soft_rst  = wr_intctl && is_soft(bus_wdata);
  assign rd_rxport = host_rd && (bus_addr == A_RXPORT);
  assign wr_txcnt  = bus_wr && (bus_addr == A_TXCNT);
  assign wr_txport = bus_wr && (bus_addr == A_TXPORT);

  assign rx_can_accept = !busy && (rx_count != LW'(MAX_LEN));

  sfnic_rx #(.MAX_LEN(MAX_LEN), .LW(LW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .s_valid(rx_valid), .s_data(rx_data), .s_last(rx_last), .s_ready(rx_ready),
    .can_accept(rx_can_accept), .pop(rd_rxport),
    .count(rx_count), .head(rx_head),
    .start_evt(rx_start), .done_evt(rx_done), .in_frame(rx_in_frame)
  );

  sfnic_tx #(.MAX_LEN(MAX_LEN), .LW(LW)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .cnt_wr(wr_txcnt), .cnt_val(bus_wdata),
    .data_wr(wr_txport), .data_byte(bus_wdata[7:0]),
    .count(tx_count), .send_evt(tx_send),
    .m_valid(tx_valid), .m_data(tx_data), .m_last(tx_last), .m_ready(tx_ready)
  );

  // Cause register and busy flag; new causes win over a same-cycle acknowledge
  always_comb begin
    intctl_nx = intctl;
    busy_nx   = busy;
    if (wr_intctl) begin
      intctl_nx = soft_rst ? (32'd1 << C_TEST) : ack_causes(intctl, bus_wdata);
    end else if (rd_intctl) begin
      intctl_nx[C_TEST] = 1'b0;
    end
    if (!soft_rst) begin
      if (rx_done) intctl_nx[C_RXDONE] = 1'b1;
      if (tx_send) intctl_nx[C_TXDONE] = 1'b1;
    end
    if (wr_intctl) busy_nx = |intctl_nx;
    if (!soft_rst && (rx_start || tx_send)) busy_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intctl <= '0;
      busy   <= 1'b1;
    end else begin
      intctl <= intctl_nx;
      busy   <= busy_nx;
    end
  end

  assign irq = |intctl;

  // Read data
  always_comb begin
    bus_rdata = '0;
    if (host_rd) begin
      case (bus_addr)
        A_ID_HI:  bus_rdata = ID_HI;
        A_ID_LO:  bus_rdata = ID_LO;
        A_BUSY:   bus_rdata = {31'd0, busy};
        A_RXCNT:  bus_rdata = 32'(rx_count);
        A_TXCNT:  bus_rdata = 32'(tx_count);
        A_ICTL:   bus_rdata = intctl;
        A_INFO:   bus_rdata = '0;
        A_RXPORT: bus_rdata = (rx_count != '0) ? {24'd0, rx_head} : 32'd0;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sfnic_chk.sv
module sfnic_chk
  import sfnic_pkg::*;
#(
  parameter int MAX_LEN = 1514,
  parameter int LW      = $clog2(MAX_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [5:0]    bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          irq,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          tx_ready,
  input logic          busy,
  input logic [31:0]   intctl,
  input logic [LW-1:0] rx_count,
  input logic [LW-1:0] tx_count,
  input logic          rx_start,
  input logic          rx_done,
  input logic          tx_send,
  input logic          wr_intctl,
  input logic          soft_rst
);
  // R3: a frame only starts while idle and not full
  a_r3_start_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |-> (!busy && (rx_count != LW'(MAX_LEN))));

  // R14: receive count never exceeds the buffer size
  a_r14_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= LW'(MAX_LEN));

  // R6: transmit count never exceeds the buffer size
  a_r6_tx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= LW'(MAX_LEN));

  // R8: a stalled byte holds
  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !soft_rst && !tx_send)
      |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R4: a completed frame raises receive done and the interrupt
  a_r4_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !soft_rst) |=> (irq && intctl[C_RXDONE]));

  // R7: a launch sets transmit done and busy
  a_r7_send_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send |=> (busy && intctl[C_TXDONE]));

  // R11: reading the cause register clears the test bit
  a_r11_read_clears_test: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && (bus_addr == A_ICTL)) |=> !intctl[C_TEST]);

  // R12: busy follows the remaining causes after a cause write
  a_r12_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_intctl && !rx_start) |=> (busy == (intctl != 32'd0)));

  // R5: empty receive port reads zero
  a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && (bus_addr == A_RXPORT) && (rx_count == '0))
      |-> (bus_rdata == 32'd0));
endmodule

bind sfnic sfnic_chk #(.MAX_LEN(MAX_LEN), .LW(LW)) u_chk (.*);

// File: tb/sfnic_bench.sv
`timescale 1ns/1ps
module sfnic_bench;
  localparam int MAX = 16;
  localparam logic [31:0] ID_A = 32'h5346_4E49;
  localparam logic [31:0] ID_B = 32'h4331_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 0, bus_wr = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, rx_ready, tx_valid, tx_last;
  logic rx_valid = 0, rx_last = 0, tx_ready = 0;
  logic [7:0] rx_data = '0;
  logic [7:0] tx_data;

  always #10 clk = ~clk;

  sfnic #(.MAX_LEN(MAX)) u_sfnic (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_busy;
  logic [31:0] m_int;
  logic [7:0]  m_rxq[$];
  logic [7:0]  m_frame[$];
  bit          m_inframe;
  int          m_txcnt;
  logic [7:0]  m_txq[$];
  logic [7:0]  m_sendq[$];
  bit          s_rdy, s_hs, s_thk, s_soft;

  function automatic bit model_ready();
    return m_inframe || (!m_busy && (m_rxq.size() != MAX));
  endfunction

  function automatic logic [31:0] model_read(logic [5:0] a);
    case (a)
      6'h00: return ID_A;
      6'h04: return ID_B;
      6'h08: return {31'd0, m_busy};
      6'h0C: return m_rxq.size();
      6'h10: return m_txcnt;
      6'h14: return m_int;
      6'h1C: return (m_rxq.size() > 0) ? {24'd0, m_rxq[0]} : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1; m_int = 0; m_inframe = 0; m_txcnt = 0;
      m_rxq.delete(); m_frame.delete(); m_txq.delete(); m_sendq.delete();
    end else begin
      s_rdy  = model_ready();
      s_hs   = rx_valid && s_rdy;
      s_thk  = (m_sendq.size() > 0) && tx_ready;
      s_soft = 0;
      if (s_thk) void'(m_sendq.pop_front());
      if (bus_wr) begin
        case (bus_addr)
          6'h10: begin m_txcnt = (bus_wdata <= MAX) ? int'(bus_wdata) : 0; m_txq.delete(); end
          6'h14: begin
            if (bus_wdata[0]) m_int[0] = 0;
            else if (bus_wdata[1]) m_int[1] = 0;
            else if (bus_wdata[31]) begin
              s_soft = 1;
              m_int = 32'h8000_0000; m_inframe = 0; m_txcnt = 0;
              m_rxq.delete(); m_frame.delete(); m_txq.delete(); m_sendq.delete();
            end
            m_busy = (m_int != 0);
          end
          6'h20: if (m_txcnt != 0) begin
            m_txq.push_back(bus_wdata[7:0]);
            if (m_txq.size() == m_txcnt) begin
              m_sendq = m_txq; m_txq.delete(); m_txcnt = 0;
              m_int[0] = 1; m_busy = 1;
            end
          end
          default: ;
        endcase
      end else if (bus_rd) begin
        if (bus_addr == 6'h14) m_int[31] = 0;
        if (bus_addr == 6'h1C && m_rxq.size() > 0) void'(m_rxq.pop_front());
      end
      if (s_hs && !s_soft) begin
        if (!m_inframe) begin m_busy = 1; m_frame.delete(); end
        if (m_frame.size() < MAX) m_frame.push_back(rx_data);
        if (rx_last) begin m_rxq = m_frame; m_int[1] = 1; m_inframe = 0; end
        else m_inframe = 1;
      end
    end
  end

  // Per-cycle comparison, away from the clock edge
  logic [7:0] got_q[$];
  int got_last_pos;
  always begin
    @(negedge clk); #5;
    if (rst_n) begin
      chk("R12 irq vs model", irq, m_int != 0);
      chk("R3 rx_ready vs model", rx_ready, model_ready());
      chk("R8 tx_valid vs model", tx_valid, m_sendq.size() > 0);
      if (m_sendq.size() > 0) begin
        chk("R8 tx_data vs model", tx_data, m_sendq[0]);
        chk("R8 tx_last vs model", tx_last, m_sendq.size() == 1);
      end
      if (bus_rd && !bus_wr) chk("R2 read data vs model", bus_rdata, model_read(bus_addr));
      if (tx_valid && tx_ready) begin
        got_q.push_back(tx_data);
        if (tx_last) got_last_pos = got_q.size();
      end
    end
  end

  // Stall pattern on the outgoing stream
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    #1 tx_ready = (cyc % 3) != 1;
  end

  // ---------------- stimulus tasks ----------------
  task automatic bwr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic brd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_rd = 1; bus_addr = a;
    #3 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic rd_chk(string tag, logic [5:0] a, logic [31:0] exp);
    logic [31:0] v;
    brd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic send_frame(int len, logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); #1;
      rx_valid = 1; rx_data = base + 8'(i); rx_last = (i == len - 1);
      #3;
      while (!rx_ready) begin @(negedge clk); #4; end
    end
    @(negedge clk); #1;
    rx_valid = 0; rx_last = 0;
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 irq low", irq, 0);
    rd_chk("R1 id high", 6'h00, ID_A);
    rd_chk("R1 id low", 6'h04, ID_B);
    rd_chk("R1 busy", 6'h08, 1);
    rd_chk("R1 rx count", 6'h0C, 0);
    rd_chk("R1 tx count", 6'h10, 0);
    rd_chk("R1 causes", 6'h14, 0);

    // R2 zero reads and ignored writes
    rd_chk("R2 info", 6'h18, 0);
    rd_chk("R2 tx port", 6'h20, 0);
    rd_chk("R2 unmapped", 6'h24, 0);
    bwr(6'h08, 0);
    rd_chk("R2 busy write ignored", 6'h08, 1);
    bwr(6'h0C, 7);
    rd_chk("R2 rx count write ignored", 6'h0C, 0);

    // R3 refused while busy
    @(negedge clk); #1 rx_valid = 1; rx_data = 8'h99; rx_last = 1;
    repeat (3) begin @(negedge clk); #4 chk("R3 refused while busy", rx_ready, 0); end
    #1 rx_valid = 0; rx_last = 0;
    rd_chk("R3 nothing stored", 6'h0C, 0);

    // R12 clear busy by writing zero
    bwr(6'h14, 0);
    rd_chk("R12 busy clears", 6'h08, 0);

    // R4 receive a frame
    send_frame(5, 8'hA0);
    rd_chk("R4 rx count", 6'h0C, 5);
    rd_chk("R4 receive done", 6'h14, 32'h2);
    rd_chk("R4 busy", 6'h08, 1);
    chk("R4 irq", irq, 1);

    // R5 drain
    for (int i = 0; i < 5; i++) rd_chk("R5 byte", 6'h1C, 32'hA0 + i);
    rd_chk("R5 count drained", 6'h0C, 0);
    rd_chk("R5 empty read", 6'h1C, 0);
    rd_chk("R5 count unchanged", 6'h0C, 0);

    // R7 / R8 transmit
    got_q.delete(); got_last_pos = 0;
    bwr(6'h10, 3);
    bwr(6'h20, 32'h111); bwr(6'h20, 32'h22); bwr(6'h20, 32'h33);
    rd_chk("R7 tx count cleared", 6'h10, 0);
    rd_chk("R7 both causes", 6'h14, 32'h3);
    rd_chk("R7 busy", 6'h08, 1);
    repeat (12) @(negedge clk);
    chk("R8 byte count", got_q.size(), 3);
    if (got_q.size() == 3) begin
      chk("R8 byte0", got_q[0], 8'h11);
      chk("R8 byte1", got_q[1], 8'h22);
      chk("R8 byte2", got_q[2], 8'h33);
    end
    chk("R8 last position", got_last_pos, 3);

    // R9 priority
    bwr(6'h14, 32'h3);
    rd_chk("R9 bit0 wins", 6'h14, 32'h2);
    bwr(6'h14, 32'h8000_0002);
    rd_chk("R9 bit1 wins over test", 6'h14, 0);
    rd_chk("R12 busy after ack", 6'h08, 0);

    // R6 count clamp and pointer restart
    bwr(6'h10, MAX + 1);
    rd_chk("R6 oversize loads zero", 6'h10, 0);
    bwr(6'h10, MAX);
    rd_chk("R6 max loads", 6'h10, MAX);
    got_q.delete(); got_last_pos = 0;
    bwr(6'h20, 32'hEE);
    bwr(6'h10, 2);
    bwr(6'h20, 32'h5A); bwr(6'h20, 32'h5B);
    repeat (10) @(negedge clk);
    chk("R6 restart count", got_q.size(), 2);
    if (got_q.size() == 2) begin
      chk("R6 restart byte0", got_q[0], 8'h5A);
      chk("R6 restart byte1", got_q[1], 8'h5B);
    end
    bwr(6'h14, 32'h1);
    rd_chk("R12 busy idle", 6'h08, 0);

    // R13 data write with zero count
    bwr(6'h20, 32'h77);
    rd_chk("R13 tx count stays", 6'h10, 0);
    rd_chk("R13 no cause", 6'h14, 0);
    repeat (3) @(negedge clk);
    #5 chk("R13 no stream", tx_valid, 0);

    // R14 truncation, and R3 full-buffer refusal
    send_frame(MAX + 3, 8'h40);
    rd_chk("R14 count saturates", 6'h0C, MAX);
    bwr(6'h14, 32'h2);
    rd_chk("R3 busy clear", 6'h08, 0);
    @(negedge clk); #1 rx_valid = 1; rx_data = 8'h01; rx_last = 1;
    #3 chk("R3 refused when full", rx_ready, 0);
    @(negedge clk); #1 rx_valid = 0; rx_last = 0;
    for (int i = 0; i < MAX; i++) rd_chk("R14 kept byte", 6'h1C, 32'h40 + i);
    rd_chk("R14 drained", 6'h0C, 0);

    // R10 / R11 soft reset
    bwr(6'h10, 5);
    bwr(6'h20, 32'h1);
    bwr(6'h14, 32'h8000_0000);
    chk("R10 irq after soft reset", irq, 1);
    rd_chk("R10 busy", 6'h08, 1);
    rd_chk("R10 tx count", 6'h10, 0);
    rd_chk("R10 rx count", 6'h0C, 0);
    rd_chk("R11 read returns test bit", 6'h14, 32'h8000_0000);
    rd_chk("R11 test bit cleared", 6'h14, 0);
    chk("R11 irq low", irq, 0);
    rd_chk("R11 busy unchanged by read", 6'h08, 1);
    bwr(6'h14, 0);
    rd_chk("R12 busy after zero write", 6'h08, 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule